// File: doc/BRIEF.md
# Port Option Loader with Core Hold-Off

This block sets the I/O pad options of a small controller from data held in program memory rather than from mask layers. Once the external reset is released, it reads a short list of option bytes from the reserved 256-byte area at the top of program memory, at 0xFF00 to 0xFFFF. It reads them in order, one per clock, through a synchronous read port. It decodes them into per-pin output-type and pull-up enables for port 0, port 1, port 3 and pins 70 to 73.

While loading runs, the block keeps the processor core in reset. A down-counter counts a fixed hold-off window; its default length is 3 ms at a 100 MHz clock. The core reset is released, and the done flag raised, in the same cycle, at the end of that window and only once every option byte has arrived. The core then starts fetching at address 0x0000. Until that moment every configuration output is in the safe state: open drain with no pull-up. From then on the outputs hold steady until the next reset.

Top module: `opt_cfg_loader`

## Requirements
- R1: After reset release, the block issues exactly OPT_BYTES (6) memory reads, one per cycle, at CFG_BASE+0 through CFG_BASE+5 in ascending order, starting at the first clock edge.
- R2: `core_rst_n` and `cfg_done` are low until HOLD_CYCLES rising clock edges have passed since reset release. Both go high together on that edge and stay high.
- R3: While `cfg_done` is low, including during reset, every configuration output is 0 (open drain, no pull-up).
- R4: `p0_cmos[i]` equals bit i of option byte 0 (1 = CMOS drive, 0 = N-channel open drain).
- R5: Bit 0 of option byte 1 enables pull-ups on port 0 pins 0–3, and bit 1 enables them on pins 4–7. Bits 7:2 are ignored. A pin whose output type is open drain has its pull-up forced off.
- R6: `p1_cmos[i]` equals bit i of option byte 2.
- R7: `p3_cmos[i]` equals bit i of option byte 3, for i = 0..5. `p3_pu[i]` equals bit i of option byte 4 ANDed with `p3_cmos[i]`. Bits 7:6 of both bytes are ignored.
- R8: `p7_pu[i]` (pins 70–73) equals bit i of option byte 5. Bits 7:4 are ignored.
- R9: Asserting reset at any time, including partway through loading or after completion, returns all outputs to the R3 state at once. The next release reloads from memory.
- R10: Once all option bytes have been read, no further memory reads occur until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | External reset, active low, asynchronous assert |
| mem_addr | output | 16 | Program memory read address |
| mem_rd | output | 1 | Read strobe; data is returned on the following cycle |
| mem_rdata | input | 8 | Read data from program memory |
| core_rst_n | output | 1 | Reset to the processor core, active low |
| cfg_done | output | 1 | Options loaded and core released |
| p0_cmos | output | 8 | Port 0 output type per pin, 1 = CMOS |
| p0_pu | output | 8 | Port 0 effective pull-up enable per pin |
| p1_cmos | output | 8 | Port 1 output type per pin, 1 = CMOS |
| p3_cmos | output | 6 | Port 3 output type per pin, 1 = CMOS |
| p3_pu | output | 6 | Port 3 effective pull-up enable per pin |
| p7_pu | output | 4 | Pull-up enable for pins 70–73 |

## Verification
A wrong read index or a lost capture shows up as a wrong bit in a configuration port. That error is visible on the very cycle the core leaves reset, because the outputs are latched exactly once. A hold-off counter that is off by one moves the rise of `core_rst_n` by one clock, so the bench measures the release edge exactly rather than within a tolerance. A sequencer that fails to stop shows up as extra reads on the memory port after loading. A missing forced-off gate shows up as a pull-up on a pin the vectors declare open drain.

// File: rtl/opt_cfg_pkg.sv
package opt_cfg_pkg;

  localparam int OPT_BYTES = 6;

  // byte positions inside the option area (decoded by opt_decode)
  localparam int IDX_P0_TYPE = 0;
  localparam int IDX_P0_PULL = 1;
  localparam int IDX_P1_TYPE = 2;
  localparam int IDX_P3_TYPE = 3;
  localparam int IDX_P3_PULL = 4;
  localparam int IDX_P7_PULL = 5;

  typedef struct packed {
    logic [7:0] p0_cmos;
    logic [7:0] p0_pu;
    logic [7:0] p1_cmos;
    logic [5:0] p3_cmos;
    logic [5:0] p3_pu;
    logic [3:0] p7_pu;
  } opt_cfg_t;

  function automatic logic [7:0] opt_byte(input logic [OPT_BYTES*8-1:0] raw, input int idx);
    return raw[idx*8 +: 8];
  endfunction

  // raw option bytes -> effective pad settings; open drain forces pull-up off
  function automatic opt_cfg_t decode_opts(input logic [OPT_BYTES*8-1:0] raw);
    opt_cfg_t   c;
    logic [1:0] nib;
    c.p0_cmos = opt_byte(raw, IDX_P0_TYPE);
    nib       = opt_byte(raw, IDX_P0_PULL) & 8'h03;
    c.p0_pu   = {{4{nib[1]}}, {4{nib[0]}}} & c.p0_cmos;
    c.p1_cmos = opt_byte(raw, IDX_P1_TYPE);
    c.p3_cmos = opt_byte(raw, IDX_P3_TYPE) & 8'h3F;
    c.p3_pu   = (opt_byte(raw, IDX_P3_PULL) & 8'h3F) & c.p3_cmos;
    c.p7_pu   = opt_byte(raw, IDX_P7_PULL) & 8'h0F;
    return c;
  endfunction

endpackage

// File: rtl/holdoff_timer.sv
module holdoff_timer #(
  parameter int CYCLES = 300000
) (
  input  logic clk,
  input  logic rst_n,
  output logic expired
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= CW'(CYCLES - 1);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R2: counter steps down by exactly one each cycle until terminal count
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(expired) && $past(rst_n)) |-> (cnt == $past(cnt) - 1'b1));

  // R2: terminal count is sticky
  a_r2_expired_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> expired);

endmodule

// File: rtl/opt_fetch.sv
module opt_fetch
  import opt_cfg_pkg::*;
#(
  parameter int               ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE  = 16'hFF00,
  parameter int               NBYTES = OPT_BYTES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic                  mem_rd,
  input  logic [7:0]            mem_rdata,
  output logic [NBYTES*8-1:0]   opt_raw,
  output logic                  loaded
);
  localparam int IW = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [IW-1:0] LAST = IW'(NBYTES - 1);

  logic          fetching;
  logic [IW-1:0] idx, idx_q;
  logic          rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetching <= 1'b1;
      idx      <= '0;
      idx_q    <= '0;
      rd_q     <= 1'b0;
      opt_raw  <= '0;
      loaded   <= 1'b0;
    end else begin
      rd_q  <= fetching;
      idx_q <= idx;
      if (fetching) begin
        if (idx == LAST) fetching <= 1'b0;
        else             idx      <= idx + 1'b1;
      end
      if (rd_q) begin
        opt_raw[idx_q*8 +: 8] <= mem_rdata;
        if (idx_q == LAST) loaded <= 1'b1;
      end
    end
  end

  assign mem_rd   = fetching;
  assign mem_addr = BASE + ADDR_W'(idx);

  // R1: reads stay inside the option area
  a_r1_addr_window: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (mem_addr >= BASE && mem_addr < BASE + ADDR_W'(NBYTES)));

  // R1: consecutive reads walk upward by one
  a_r1_sequential: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd) && $past(rst_n)) |-> (mem_addr == $past(mem_addr) + 1'b1));

  // R10: no reads once every byte has arrived
  a_r10_reads_stop: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |-> !mem_rd);

endmodule

// File: rtl/opt_decode.sv
module opt_decode
  import opt_cfg_pkg::*;
(
  input  logic [OPT_BYTES*8-1:0] opt_raw,
  output opt_cfg_t               cfg
);
  always_comb cfg = decode_opts(opt_raw);
endmodule

// File: rtl/opt_cfg_loader.sv
module opt_cfg_loader
  import opt_cfg_pkg::*;
#(
  parameter int               ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] CFG_BASE   = 16'hFF00,
  parameter int               CLK_HZ      = 100_000_000,
  parameter int               HOLD_US     = 3000,
  parameter int               HOLD_CYCLES = (CLK_HZ / 1_000_000) * HOLD_US
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [7:0]        mem_rdata,
  output logic              core_rst_n,
  output logic              cfg_done,
  output logic [7:0]        p0_cmos,
  output logic [7:0]        p0_pu,
  output logic [7:0]        p1_cmos,
  output logic [5:0]        p3_cmos,
  output logic [5:0]        p3_pu,
  output logic [3:0]        p7_pu
);
  logic [OPT_BYTES*8-1:0] opt_raw;
  logic                   loaded;
  logic                   expired;
  opt_cfg_t               cfg_next;
  opt_cfg_t               cfg_q;
  logic                   done_q;
  logic                   finish_ev;

  opt_fetch #(.ADDR_W(ADDR_W), .BASE(CFG_BASE), .NBYTES(OPT_BYTES)) u_fetch (
    .clk(clk), .rst_n(rst_n),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .opt_raw(opt_raw), .loaded(loaded)
  );

  holdoff_timer #(.CYCLES(HOLD_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .expired(expired)
  );

  opt_decode u_dec (.opt_raw(opt_raw), .cfg(cfg_next));

  assign finish_ev = !done_q && expired && loaded;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      cfg_q  <= '0;
    end else if (finish_ev) begin
      done_q <= 1'b1;
      cfg_q  <= cfg_next;
    end
  end

  assign core_rst_n = done_q;
  assign cfg_done   = done_q;
  assign p0_cmos    = cfg_q.p0_cmos;
  assign p0_pu      = cfg_q.p0_pu;
  assign p1_cmos    = cfg_q.p1_cmos;
  assign p3_cmos    = cfg_q.p3_cmos;
  assign p3_pu      = cfg_q.p3_pu;
  assign p7_pu      = cfg_q.p7_pu;

  // R3: safe pad state until loading completes
  a_r3_safe_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_done |-> (p0_cmos == '0 && p0_pu == '0 && p1_cmos == '0 &&
                   p3_cmos == '0 && p3_pu == '0 && p7_pu == '0));

  // R2: release only after the window and a complete load
  a_r2_release_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_done) |-> (expired && loaded));

  // R2: release is permanent until reset
  a_r2_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> (cfg_done && $stable(cfg_q)));

  // R5 / R7: open-drain pins never show a pull-up
  a_r5_od_no_pullup: assert property (@(posedge clk) disable iff (!rst_n)
    ((p0_pu & ~p0_cmos) == '0) && ((p3_pu & ~p3_cmos) == '0));

endmodule

// File: tb/opt_cfg_loader_test.sv
module opt_cfg_loader_test;
  localparam int HOLD = 40;
  localparam logic [15:0] BASE = 16'hFF00;
  localparam int NV = 5;
  // {b5,b4,b3,b2,b1,b0}
  localparam logic [47:0] VEC [NV] = '{
    48'hFF_FF_FF_FF_FF_FF,
    48'h00_00_00_00_00_00,
    48'hF5_3F_15_5A_FE_F0,
    48'h0A_2A_3C_81_01_0F,
    48'hF0_FF_C0_00_03_3C
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic mem_rd;
  logic [7:0] mem_rdata = 8'h00;
  logic core_rst_n, cfg_done;
  logic [7:0] p0_cmos, p0_pu, p1_cmos;
  logic [5:0] p3_cmos, p3_pu;
  logic [3:0] p7_pu;

  logic [7:0] cfg_mem [256];
  int rd_n;
  logic [15:0] rd_log [16];
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  opt_cfg_loader #(.HOLD_CYCLES(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .core_rst_n(core_rst_n), .cfg_done(cfg_done),
    .p0_cmos(p0_cmos), .p0_pu(p0_pu), .p1_cmos(p1_cmos),
    .p3_cmos(p3_cmos), .p3_pu(p3_pu), .p7_pu(p7_pu)
  );

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= (mem_addr[15:8] == 8'hFF) ? cfg_mem[mem_addr[7:0]] : 8'h00;
    if (rst_n && mem_rd) begin
      if (rd_n < 16) rd_log[rd_n] <= mem_addr;
      rd_n <= rd_n + 1;
    end
  end

  function automatic logic [39:0] outs();
    return {p0_cmos, p0_pu, p1_cmos, p3_cmos, p3_pu, p7_pu};
  endfunction

  // expected pad settings, built pin by pin
  function automatic logic [39:0] expect_cfg(input logic [47:0] v);
    logic [7:0] a, b, c;
    logic [5:0] d, e;
    logic [3:0] f;
    for (int i = 0; i < 8; i++) begin
      a[i] = v[i];
      b[i] = v[i] & v[8 + (i / 4)];
      c[i] = v[16 + i];
    end
    for (int i = 0; i < 6; i++) begin
      d[i] = v[24 + i];
      e[i] = v[32 + i] & v[24 + i];
    end
    for (int i = 0; i < 4; i++) f[i] = v[40 + i];
    return {a, b, c, d, e, f};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_mem(input logic [47:0] v);
    for (int i = 0; i < 256; i++) cfg_mem[i] = 8'hA5;
    for (int i = 0; i < 6; i++) cfg_mem[i] = v[i*8 +: 8];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3 reset outputs", {22'd0, cfg_done, core_rst_n, outs()}, 64'd0);
    rd_n = 0;
    rst_n = 1'b1;
  endtask

  // runs from release through completion; checks timing and safe state
  task automatic run_load(input logic [47:0] v);
    int bad_t;
    int bad_s;
    bad_t = 0;
    bad_s = 0;
    for (int k = 1; k <= HOLD + 3; k++) begin
      @(negedge clk);
      if (core_rst_n !== (k >= HOLD) || cfg_done !== (k >= HOLD)) bad_t++;
      if (k < HOLD && outs() !== 40'd0) bad_s++;
    end
    chk("R2 release edge", 64'(bad_t), 64'd0);
    chk("R3 safe while held", 64'(bad_s), 64'd0);
    chk("R4-R8 decoded options", 64'(outs()), 64'(expect_cfg(v)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    rd_n = 0;
    load_mem(VEC[0]);
    for (int n = 0; n < NV; n++) begin
      load_mem(VEC[n]);
      do_reset();
      run_load(VEC[n]);
      // R1 read sequence
      chk("R1 read count", 64'(rd_n), 64'd6);
      for (int i = 0; i < 6; i++) chk("R1 read address", 64'(rd_log[i]), 64'(BASE + 16'(i)));
      repeat (5) @(negedge clk);
      chk("R10 no reads after load", 64'(rd_n), 64'd6);
    end

    // field checks on vector 2 (R4..R8 named individually)
    load_mem(VEC[2]);
    do_reset();
    run_load(VEC[2]);
    chk("R4 p0 type", 64'(p0_cmos), 64'h F0);
    chk("R5 p0 nibble pull-up", 64'(p0_pu), 64'h F0);
    chk("R6 p1 type", 64'(p1_cmos), 64'h5A);
    chk("R7 p3 type/pull", 64'({p3_cmos, p3_pu}), 64'({6'h15, 6'h15}));
    chk("R8 p70-73 pull-up", 64'(p7_pu), 64'h5);

    // R5 corner: low nibble pull-up with mixed types, junk upper bits
    load_mem(48'h00_00_00_00_FD_3C);
    do_reset();
    run_load(48'h00_00_00_00_FD_3C);
    chk("R5 low nibble only, OD forced off", 64'(p0_pu), 64'h0C);

    // R9: reset after completion returns safe state immediately
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9 reset after done", 64'({cfg_done, core_rst_n, outs()}), 64'd0);

    // R9: reset partway through loading, then reload different data
    load_mem(VEC[0]);
    do_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9 reset mid-load", 64'({cfg_done, core_rst_n, outs()}), 64'd0);
    load_mem(VEC[3]);
    do_reset();
    run_load(VEC[3]);
    chk("R9 reload after mid-load reset", 64'(outs()), 64'(expect_cfg(VEC[3])));
    chk("R1 reload read count", 64'(rd_n), 64'd6);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule